// File: doc/BRIEF.md
# Audio Subframe Error Status Unit

This unit sits behind a digital audio receiver whose line decoding and clock recovery are done elsewhere. Each decoded 32-bit subframe arrives with a one-cycle strobe. The unit checks the subframe's parity and its validity, user and channel-status bits. It also watches a level from the clock-recovery loop that says whether that loop is locked. Every event sets a sticky flag. A flag stays set until software writes a 1 to that flag's own bit in the status register.

A small register port gives software two registers. The status register reads the flags and clears them with write-one-to-clear. The enable register is read/write and masks which flags may raise the interrupt. The interrupt is a single registered, active-high line formed from the enabled flags. The flag vector is also available as a separate output.

Top module: `audio_err_status`

## Requirements
- R1: After reset, all five flags, all interrupt enables and the interrupt output are 0.
- R2: A strobed subframe whose bits [31:4] contain an odd number of ones sets the parity flag (status bit 3) at that clock edge. Bits [3:0], which carry the preamble code, have no effect on the parity check.
- R3: A strobed subframe with bit 28 (validity) at 1 sets the validity flag (status bit 2) at that clock edge.
- R4: A strobed subframe with bit 29 (user) or bit 30 (channel status) at 1 sets the user/channel flag (status bit 4).
- R5: The lock input passes through SYNC_STAGES synchronizer flops. A rising edge after synchronization sets the lock flag (status bit 0) and a falling edge sets the unlock flag (status bit 1). No subframe or preamble activity is needed for either.
- R6: A flag, once set, holds until a write to the status address (address 0) with a 1 in that flag's bit position. Writing 0 bits there, writing the enable register, or sending subframes that raise no event all leave the flag unchanged.
- R7: When a set event and a clear write for the same flag fall in the same cycle, the flag ends up 1. Other flags cleared by the same write still clear.
- R8: The enable register is at address 1. Its bits 0, 1, 2 and 4 enable lock, unlock, validity and user/channel. Bit 3 has no enable: it reads 0 and ignores writes. Unmapped addresses read 0.
- R9: The interrupt output equals the OR of each flag ANDed with its enable, delayed by one register stage. A flag set at clock edge E raises the interrupt at edge E+1.
- R10: When the strobe is low, the subframe input has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | Strobe: sf_data holds a subframe this cycle |
| sf_data | input | 32 | Decoded subframe word |
| lock_in | input | 1 | Lock level from the clock-recovery loop (asynchronous) |
| reg_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data for reg_addr |
| stat_flags | output | 5 | Sticky flag vector |
| irq | output | 1 | Registered interrupt, active high |

## Verification
The parity check of an incoming subframe and a software clear of the parity flag can land on the same clock edge. The bench first sets the parity and validity flags. It then issues, in one cycle, a status write that clears both of them together with a strobed subframe that has bad parity. The result is judged correct only if the parity flag reads 1 and the validity flag reads 0 afterwards, which shows that the set wins and that the other clear bit still takes effect.

// File: rtl/audio_stat_pkg.sv
package audio_stat_pkg;

  localparam int NUM_FLAGS = 5;

  // Flag positions in the status and enable registers.
  localparam int F_LOCK   = 0;
  localparam int F_UNLOCK = 1;
  localparam int F_VERR   = 2;
  localparam int F_PERR   = 3;
  localparam int F_UCB    = 4;

  // Subframe bit positions.
  localparam int SF_PAR_LO = 4;
  localparam int SF_PAR_HI = 31;
  localparam int SF_VBIT   = 28;
  localparam int SF_UBIT   = 29;
  localparam int SF_CBIT   = 30;

  // Flags that may be enabled for the interrupt.
  localparam logic [NUM_FLAGS-1:0] EN_WRITABLE =
    NUM_FLAGS'((1 << F_LOCK) | (1 << F_UNLOCK) | (1 << F_VERR) | (1 << F_UCB));

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // One when the covered range holds an odd number of ones.
  function automatic logic odd_ones(input logic [SF_PAR_HI-SF_PAR_LO:0] bits);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i <= SF_PAR_HI - SF_PAR_LO; i++) acc = acc ^ bits[i];
    return acc;
  endfunction

endpackage

// File: rtl/sf_checker.sv
module sf_checker
  import audio_stat_pkg::*;
(
  input  logic                       sf_valid,
  input  logic [SF_PAR_HI:SF_PAR_LO] sf_body,
  output logic                       ev_perr,
  output logic                       ev_verr,
  output logic                       ev_ucb
);
  always_comb begin
    ev_perr = sf_valid && odd_ones(sf_body);
    ev_verr = sf_valid && sf_body[SF_VBIT];
    ev_ucb  = sf_valid && (sf_body[SF_UBIT] || sf_body[SF_CBIT]);
  end
endmodule

// File: rtl/lock_edge_det.sv
module lock_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic lock_rise,
  output logic lock_fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lock_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= lock_async;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_async};
    end
  endgenerate

  assign lock_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lock_s;

  assign lock_rise = lock_s & ~prev_q;
  assign lock_fall = ~lock_s & prev_q;
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_ev[i])  flags[i] <= 1'b1;
      else if (clr_req[i]) flags[i] <= 1'b0;
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & enables);
endmodule

// File: rtl/audio_err_status.sv
module audio_err_status
  import audio_stat_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sf_valid,
  input  logic [31:0]          sf_data,
  input  logic                 lock_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [NUM_FLAGS-1:0] reg_wdata,
  output logic [NUM_FLAGS-1:0] reg_rdata,
  output logic [NUM_FLAGS-1:0] stat_flags,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);

  // Named internal events, visible to the bound checker.
  logic      ev_perr, ev_verr, ev_ucb;
  logic      lock_rise, lock_fall;
  flag_vec_t set_vec;
  flag_vec_t clr_mask;
  flag_vec_t en_q;
  logic [3:0] sf_preamble;

  assign sf_preamble = sf_data[3:0];

  sf_checker u_chk_sf (
    .sf_valid (sf_valid),
    .sf_body  (sf_data[SF_PAR_HI:SF_PAR_LO]),
    .ev_perr  (ev_perr),
    .ev_verr  (ev_verr),
    .ev_ucb   (ev_ucb)
  );

  lock_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_async (lock_in),
    .lock_rise  (lock_rise),
    .lock_fall  (lock_fall)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[F_LOCK]   = lock_rise;
    set_vec[F_UNLOCK] = lock_fall;
    set_vec[F_VERR]   = ev_verr;
    set_vec[F_PERR]   = ev_perr;
    set_vec[F_UCB]    = ev_ucb;
  end

  assign clr_mask = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : '0;

  sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_vec),
    .clr_req (clr_mask),
    .flags   (stat_flags)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               en_q <= '0;
    else if (reg_wr && reg_addr == A_ENABLE)  en_q <= reg_wdata & EN_WRITABLE;

  irq_gen #(.N(NUM_FLAGS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (stat_flags),
    .enables (en_q),
    .irq     (irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_STATUS: reg_rdata = stat_flags;
      A_ENABLE: reg_rdata = en_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_err_status_chk.sv
module audio_err_status_chk
  import audio_stat_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sf_valid,
  input logic [31:0]          sf_data,
  input logic [3:0]           sf_preamble,
  input logic                 lock_rise,
  input logic                 lock_fall,
  input logic [NUM_FLAGS-1:0] clr_mask,
  input logic [NUM_FLAGS-1:0] en_q,
  input logic [NUM_FLAGS-1:0] stat_flags,
  input logic                 irq
);
  // R1: flags and interrupt are clear one edge into reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (stat_flags == '0 && irq == 1'b0 && en_q == '0));

  // R2: odd ones above the preamble nibble raise the parity flag
  a_r2_parity_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && ($countones(sf_data[31:4]) % 2 == 1)) |=> stat_flags[F_PERR]);

  // R2: preamble nibble is part of the word but outside the check
  a_r2_preamble_width: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && ($countones(sf_data) - $countones(sf_preamble)) % 2 == 1)
      |=> stat_flags[F_PERR]);

  // R3: validity bit raises the validity flag
  a_r3_validity_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && sf_data[28]) |=> stat_flags[F_VERR]);

  // R5: synchronized edges set lock / unlock
  a_r5_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |=> stat_flags[F_LOCK]);
  a_r5_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fall |=> stat_flags[F_UNLOCK]);

  // R6: a set flag survives any cycle without its clear bit
  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_flags) & ~$past(clr_mask)) & ~stat_flags) == '0));

  // R8: the parity position has no enable
  a_r8_no_perr_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[F_PERR] == 1'b0);

  // R9: interrupt only follows an enabled flag one edge earlier
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((stat_flags & en_q) != '0));
endmodule

bind audio_err_status audio_err_status_chk u_err_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sf_valid    (sf_valid),
  .sf_data     (sf_data),
  .sf_preamble (sf_preamble),
  .lock_rise   (lock_rise),
  .lock_fall   (lock_fall),
  .clr_mask    (clr_mask),
  .en_q        (en_q),
  .stat_flags  (stat_flags),
  .irq         (irq)
);

// File: tb/tb_audio_err_status.sv
module tb_audio_err_status;
  localparam int NF = 5;
  localparam int B_LOCK = 0, B_UNLOCK = 1, B_VERR = 2, B_PERR = 3, B_UCB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sf_valid = 1'b0;
  logic [31:0]   sf_data = '0;
  logic          lock_in = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [NF-1:0] reg_wdata = '0;
  logic [NF-1:0] reg_rdata, stat_flags;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  audio_err_status dut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_data(sf_data),
    .lock_in(lock_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_flags(stat_flags),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Build a subframe; good_par picks bit 31 so bits [31:4] hold even ones.
  function automatic logic [31:0] mk_sf(input logic [23:0] audio, input logic v,
                                        input logic u, input logic c,
                                        input logic [3:0] pre, input logic good_par);
    logic [31:0] w;
    int ones;
    w = {1'b0, c, u, v, audio, pre};
    ones = 0;
    for (int i = 4; i < 31; i++) ones += int'(w[i]);
    w[31] = good_par ? ((ones % 2) == 1) : ((ones % 2) == 0);
    return w;
  endfunction

  task automatic send_sf(input logic [31:0] w);
    @(negedge clk); sf_valid = 1'b1; sf_data = w;
    @(negedge clk); sf_valid = 1'b0; sf_data = 32'hFFFF_FFFF;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [NF-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [NF-1:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0;
  endtask

  task automatic t_reset;
    logic [NF-1:0] d;
    check("R1 flags", 32'(stat_flags), 0);
    check("R1 irq", 32'(irq), 0);
    rd_reg(2'd1, d);
    check("R1 enables", 32'(d), 0);
  endtask

  task automatic t_parity;
    send_sf(mk_sf(24'h5A5A5A, 0, 0, 0, 4'h0, 1));
    check("R2 good parity", 32'(stat_flags), 0);
    send_sf(mk_sf(24'h000001, 0, 0, 0, 4'hF, 1));
    send_sf(mk_sf(24'h123456, 0, 0, 0, 4'h7, 1));
    check("R2 preamble ignored", 32'(stat_flags), 0);
    send_sf(mk_sf(24'h123456, 0, 0, 0, 4'h0, 0));
    check("R2 bad parity", 32'(stat_flags), 32'(1 << B_PERR));
    wr_reg(2'd0, NF'(1 << B_PERR));
    check("R6 clear parity", 32'(stat_flags), 0);
  endtask

  task automatic t_validity_ucb;
    send_sf(mk_sf(24'h000ABC, 1, 0, 0, 4'h3, 1));
    check("R3 validity", 32'(stat_flags), 32'(1 << B_VERR));
    wr_reg(2'd0, NF'(1 << B_VERR));
    send_sf(mk_sf(24'h000ABC, 0, 1, 0, 4'h3, 1));
    check("R4 user bit", 32'(stat_flags), 32'(1 << B_UCB));
    wr_reg(2'd0, NF'(1 << B_UCB));
    send_sf(mk_sf(24'h000ABC, 0, 0, 1, 4'h3, 1));
    check("R4 channel bit", 32'(stat_flags), 32'(1 << B_UCB));
    wr_reg(2'd0, NF'(1 << B_UCB));
    check("R6 clear ucb", 32'(stat_flags), 0);
  endtask

  task automatic t_no_strobe;
    @(negedge clk); sf_valid = 1'b0; sf_data = mk_sf(24'hFFFFFF, 1, 1, 1, 4'h0, 0);
    repeat (3) @(negedge clk);
    check("R10 no strobe", 32'(stat_flags), 0);
  endtask

  task automatic t_lock;
    @(negedge clk); lock_in = 1'b1;
    @(negedge clk);
    check("R5 lock not before sync", 32'(stat_flags), 0);
    repeat (3) @(negedge clk);
    check("R5 lock rise", 32'(stat_flags), 32'(1 << B_LOCK));
    lock_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 unlock fall", 32'(stat_flags), 32'((1 << B_LOCK) | (1 << B_UNLOCK)));
    wr_reg(2'd0, '0);
    wr_reg(2'd1, NF'(1 << B_LOCK));
    check("R6 zero write and enable write keep flags", 32'(stat_flags),
          32'((1 << B_LOCK) | (1 << B_UNLOCK)));
    wr_reg(2'd1, '0);
    wr_reg(2'd0, NF'((1 << B_LOCK) | (1 << B_UNLOCK)));
    check("R6 clear lock/unlock", 32'(stat_flags), 0);
  endtask

  task automatic t_irq;
    logic [NF-1:0] d;
    wr_reg(2'd1, 5'h1F);
    rd_reg(2'd1, d);
    check("R8 enable readback no perr bit", 32'(d), 32'h17);
    rd_reg(2'd2, d);
    check("R8 unmapped reads zero", 32'(d), 0);
    send_sf(mk_sf(24'h111111, 0, 0, 0, 4'h0, 0));
    check("R9 perr flag", 32'(stat_flags), 32'(1 << B_PERR));
    @(negedge clk);
    check("R9 perr masked", 32'(irq), 0);
    @(negedge clk); sf_valid = 1'b1; sf_data = mk_sf(24'h1, 1, 0, 0, 4'h0, 1);
    @(negedge clk); sf_valid = 1'b0;
    check("R9 irq one edge late", 32'(irq), 0);
    @(negedge clk);
    check("R9 irq raised", 32'(irq), 1);
    wr_reg(2'd0, NF'(1 << B_VERR));
    check("R9 irq held until next edge", 32'(irq), 1);
    @(negedge clk);
    check("R9 irq drops", 32'(irq), 0);
    wr_reg(2'd1, '0);
    send_sf(mk_sf(24'h1, 1, 0, 0, 4'h0, 1));
    @(negedge clk);
    check("R9 verr masked", 32'(irq), 0);
  endtask

  task automatic t_collision;
    // Flags now: PERR and VERR set. Clear both while a bad subframe arrives.
    check("R7 precondition", 32'(stat_flags), 32'((1 << B_PERR) | (1 << B_VERR)));
    @(negedge clk);
    sf_valid = 1'b1; sf_data = mk_sf(24'h00F00F, 0, 0, 0, 4'h9, 0);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = NF'((1 << B_PERR) | (1 << B_VERR));
    @(negedge clk);
    sf_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    check("R7 set wins", 32'(stat_flags), 32'(1 << B_PERR));
    wr_reg(2'd0, NF'(1 << B_PERR));
    check("R7 later clear", 32'(stat_flags), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_parity();
    t_validity_ucb();
    t_no_strobe();
    t_lock();
    t_irq();
    t_collision();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule